// File: doc/BRIEF.md
# Pipelined synchronous burst SRAM

A synchronous static memory with a four-beat burst address counter and a pipelined read path. Each word is split into byte lanes of nine bits (eight data bits and one parity bit). Every control input is captured on the rising clock edge. A new external address can be loaded by either of two strobes. The CPU-side strobe always starts a read. The controller-side strobe starts a write or a read, depending on the write enables. Between loads, an advance input steps through the burst. When advance is not asserted, the current beat is held, which gives a wait state.

The three chip enables are looked at only on cycles that load an address. A failed enable check deselects the device until the next load. Read data passes through an address stage and an output register, so it is driven two clock edges after the access is accepted. An asynchronous active-low output enable gates the data drivers and nothing else. The default depth is kept small for simulation. Setting `ADDR_W` to 17 gives a 128K-word part.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held and after it is released with no load, the device is deselected and `dq_oe` is 0.
- R2: A selected CPU-strobe load (`cpu_load_n`=0 with `en_main_n`=0, `en_aux_n`=0, `en_hi`=1) reads the word at `addr`. If `drive_n` is 0, that word is on `dq_out` with `dq_oe`=1 after the second rising edge that follows.
- R3: While `en_main_n` is 1, `cpu_load_n` is ignored. With `ctl_load_n` high, the cycle continues the current burst.
- R4: A CPU-strobe load never writes, whatever `wr_all_n`, `wr_lane_gate_n` and `lane_sel_n` hold.
- R5: When a write cycle has `wr_all_n`=0, all lanes are written from `dq_in`, regardless of `wr_lane_gate_n` and `lane_sel_n`.
- R6: When `wr_all_n`=1 and `wr_lane_gate_n`=0, lane k (bits 9k+8 down to 9k) is written only if `lane_sel_n[k]`=0. When both `wr_all_n` and `wr_lane_gate_n` are 1, the cycle is a read.
- R7: The chip enables are sampled only on load cycles. Changing them during a burst does not affect it.
- R8: A load with `en_hi`=0, `en_aux_n`=1, or `en_main_n`=1 (controller strobe) deselects the device. `dq_oe` drops to 0 one cycle after the deselect is registered, and no access takes place until the next selected load.
- R9: Each `step_n`=0 cycle in a burst moves to the next beat. The two low address bits count as start+k mod 4, and the upper bits stay at the loaded value.
- R10: With `step_n`=1 and no load, the burst address holds, and an active read repeats the same word.
- R11: A write in a continuation cycle goes to the beat selected in that same cycle, with the advance applied first.
- R12: `drive_n` acts combinationally: `dq_oe` = 0 whenever `drive_n` = 1, and read data reappears without a clock once it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| en_main_n | input | 1 | Primary chip enable, active low; also qualifies the CPU strobe |
| en_aux_n | input | 1 | Secondary chip enable, active low |
| en_hi | input | 1 | Chip enable, active high |
| cpu_load_n | input | 1 | CPU-side address strobe, active low, read-only |
| ctl_load_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_lane_gate_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write enables, active low |
| drive_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe | output | 1 | Data drivers active |

## Verification
Every word of the array is written in controller-strobe bursts that start at each of the four beat offsets, and then read back in CPU-strobe bursts that start at a different offset. This shows whether the wrap keeps the upper address bits and whether a wait state repeats the right word. Directed patterns then try each of the three write encodings against the same lane masks. These show whether the CPU strobe, the whole-word write and the lane gate each have their intended priority. Each enable is deselected on its own, and enables are toggled in mid-burst, to tell sampling at load apart from sampling on every cycle.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
   // Kind of access a cycle performs once load and select are resolved.
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   // Lane write mask as an unsized-lane helper: all lanes on.
   function automatic logic [31:0] all_lanes(input int unsigned n);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < int'(n)) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/sburst_addr_gen.sv
module sburst_addr_gen #(
   parameter int ADDR_W     = 8,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              sel,
   input  logic              step_n,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic              active,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] burst_addr
);
   localparam int BB = BURST_BITS;

   logic              act_q;
   logic [ADDR_W-1:0] base_q;
   logic [BB-1:0]     cnt_q;
   logic [BB-1:0]     cnt_nxt;
   logic [BB-1:0]     lo_cur;
   logic [BB-1:0]     lo_nxt;

   always_comb begin
      cnt_nxt = step_n ? cnt_q : cnt_q + BB'(1);
      lo_cur  = base_q[BB-1:0] + cnt_q;
      lo_nxt  = base_q[BB-1:0] + cnt_nxt;
   end

   assign eff_addr   = load ? ext_addr : {base_q[ADDR_W-1:BB], lo_nxt};
   assign burst_addr = {base_q[ADDR_W-1:BB], lo_cur};
   assign active     = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         act_q  <= sel;
         base_q <= ext_addr;
         cnt_q  <= '0;
      end else if (act_q) begin
         cnt_q  <= cnt_nxt;
      end
   end
endmodule

// File: rtl/sburst_wr_decode.sv
module sburst_wr_decode #(
   parameter int LANES = 2
) (
   input  logic             go,
   input  logic             cpu_load,
   input  logic             wr_all_n,
   input  logic             wr_lane_gate_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_we,
   output sburst_pkg::acc_kind_e kind
);
   import sburst_pkg::*;

   logic [LANES-1:0] raw;

   always_comb begin
      if (cpu_load)             raw = '0;
      else if (!wr_all_n)       raw = LANES'(all_lanes(LANES));
      else if (!wr_lane_gate_n) raw = ~lane_sel_n;
      else                      raw = '0;
      lane_we = go ? raw : '0;
      if (!go)           kind = ACC_NONE;
      else if (|raw)     kind = ACC_WRITE;
      else               kind = ACC_READ;
   end
endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    rd_req,
   output logic [LANES*LANE_W-1:0] q,
   output logic                    q_valid
);
   localparam int DEPTH = 1 << ADDR_W;

   logic              s1_v;
   logic [ADDR_W-1:0] s1_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_a    <= '0;
         q_valid <= 1'b0;
      end else begin
         s1_v    <= rd_req;
         s1_a    <= acc_addr;
         q_valid <= s1_v;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (lane_we[g]) mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane_q <= '0;
         else        lane_q <= mem[s1_a];
      end

      assign q[g*LANE_W +: LANE_W] = lane_q;
   end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
   parameter int ADDR_W     = 8,
   parameter int LANES      = 2,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    en_main_n,
   input  logic                    en_aux_n,
   input  logic                    en_hi,
   input  logic                    cpu_load_n,
   input  logic                    ctl_load_n,
   input  logic                    step_n,
   input  logic                    wr_all_n,
   input  logic                    wr_lane_gate_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    drive_n,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   import sburst_pkg::*;

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W <= BURST_BITS) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_BITS");
   end
   if (BURST_BITS < 1) begin : g_bad_burst
      $error("BURST_BITS must be at least 1");
   end
   if (LANES < 1 || LANES > 32) begin : g_bad_lanes
      $error("LANES must be 1..32");
   end

   logic              cpu_load;
   logic              ctl_load;
   logic              load;
   logic              sel;
   logic              go;
   logic              active;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] burst_addr;
   logic [LANES-1:0]  lane_we;
   acc_kind_e         kind;
   logic [DATA_W-1:0] q;
   logic              q_valid;

   assign cpu_load = !cpu_load_n && !en_main_n;
   assign ctl_load = !ctl_load_n && !cpu_load;
   assign load     = cpu_load || ctl_load;
   assign sel      = !en_main_n && !en_aux_n && en_hi;
   assign go       = load ? sel : active;

   sburst_addr_gen #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .sel        (sel),
      .step_n     (step_n),
      .ext_addr   (addr),
      .active     (active),
      .eff_addr   (eff_addr),
      .burst_addr (burst_addr)
   );

   sburst_wr_decode #(.LANES(LANES)) u_dec (
      .go             (go),
      .cpu_load       (cpu_load),
      .wr_all_n       (wr_all_n),
      .wr_lane_gate_n (wr_lane_gate_n),
      .lane_sel_n     (lane_sel_n),
      .lane_we        (lane_we),
      .kind           (kind)
   );

   sburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_we  (lane_we),
      .acc_addr (eff_addr),
      .wdata    (dq_in),
      .rd_req   (kind == ACC_READ),
      .q        (q),
      .q_valid  (q_valid)
   );

   assign dq_oe  = q_valid && !drive_n;
   assign dq_out = dq_oe ? q : '0;
endmodule

// File: rtl/sburst_checker.sv
module sburst_checker #(
   parameter int ADDR_W     = 8,
   parameter int LANES      = 2,
   parameter int BURST_BITS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_main_n,
   input logic              en_aux_n,
   input logic              en_hi,
   input logic              cpu_load_n,
   input logic              ctl_load_n,
   input logic              step_n,
   input logic              wr_all_n,
   input logic              wr_lane_gate_n,
   input logic              drive_n,
   input logic              dq_oe,
   input logic [LANES-1:0]  lane_we,
   input logic [ADDR_W-1:0] burst_addr
);
   localparam int BB = BURST_BITS;

   logic ck_cpu;
   logic ck_load;
   logic ck_sel;

   assign ck_cpu  = !cpu_load_n && !en_main_n;
   assign ck_load = ck_cpu || !ctl_load_n;
   assign ck_sel  = !en_main_n && !en_aux_n && en_hi;

   // R12: drivers are off whenever the output enable is high
   a_r12_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
      drive_n |-> !dq_oe);

   // R2: selected CPU load drives data two edges later
   a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_cpu && ck_sel) |=> ##1 (drive_n || dq_oe));

   // R8: deselect at a load stops the drivers
   a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_load && !ck_sel) |=> ##1 !dq_oe);

   // R4: CPU-strobe load never writes a lane
   a_r4_cpu_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      ck_cpu |-> (lane_we == '0));

   // R6: with both write controls inactive no lane is written
   a_r6_no_gate_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!ck_cpu && wr_all_n && wr_lane_gate_n) |-> (lane_we == '0));

   // R10: wait state holds the burst address
   a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ck_load && step_n) |=> $stable(burst_addr));

   // R9: advancing never alters the upper address bits
   a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!ck_load && !step_n) |=>
         (burst_addr[ADDR_W-1:BB] == $past(burst_addr[ADDR_W-1:BB])));
endmodule

bind sync_burst_sram sburst_checker #(
   .ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .en_main_n      (en_main_n),
   .en_aux_n       (en_aux_n),
   .en_hi          (en_hi),
   .cpu_load_n     (cpu_load_n),
   .ctl_load_n     (ctl_load_n),
   .step_n         (step_n),
   .wr_all_n       (wr_all_n),
   .wr_lane_gate_n (wr_lane_gate_n),
   .drive_n        (drive_n),
   .dq_oe          (dq_oe),
   .lane_we        (lane_we),
   .burst_addr     (burst_addr)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int NL = 2;
   localparam int LW = 9;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          en_main_n = 1'b0, en_aux_n = 1'b0, en_hi = 1'b1;
   logic          cpu_load_n = 1'b1, ctl_load_n = 1'b1, step_n = 1'b1;
   logic          wr_all_n = 1'b1, wr_lane_gate_n = 1'b1;
   logic [NL-1:0] lane_sel_n = '1;
   logic          drive_n = 1'b0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model
   logic [DW-1:0] mem_m [DEPTH];
   bit            m_act = 0;
   int            m_base = 0;
   int            m_cnt = 0;
   bit            s1v = 0, s2v = 0;
   logic [DW-1:0] s1d = '0, s2d = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_burst_sram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .en_main_n(en_main_n),
      .en_aux_n(en_aux_n), .en_hi(en_hi), .cpu_load_n(cpu_load_n),
      .ctl_load_n(ctl_load_n), .step_n(step_n), .wr_all_n(wr_all_n),
      .wr_lane_gate_n(wr_lane_gate_n), .lane_sel_n(lane_sel_n),
      .drive_n(drive_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 1237 + 91) ^ (a << 9));
   endfunction

   task automatic idle();
      cpu_load_n = 1; ctl_load_n = 1; step_n = 1;
      wr_all_n = 1; wr_lane_gate_n = 1; lane_sel_n = '1;
      en_main_n = 0; en_aux_n = 0; en_hi = 1;
   endtask

   // One clock: model the access, clock it, then check outputs at negedge.
   task automatic step(input string tag);
      bit lp, lc, ld, sel, go;
      int cnt_n, ea;
      logic [NL-1:0] we;
      bit nv;
      logic [DW-1:0] nd;
      lp  = !cpu_load_n && !en_main_n;
      lc  = !ctl_load_n && !lp;
      ld  = lp || lc;
      sel = !en_main_n && !en_aux_n && en_hi;
      go  = ld ? sel : m_act;
      cnt_n = step_n ? m_cnt : (m_cnt + 1) % 4;
      ea = ld ? int'(addr) : ((m_base & ~3) | (((m_base & 3) + cnt_n) % 4));
      if (lp)                  we = '0;
      else if (!wr_all_n)      we = '1;
      else if (!wr_lane_gate_n) we = ~lane_sel_n;
      else                     we = '0;
      if (!go) we = '0;
      nv = go && (we == '0);
      nd = mem_m[ea];
      @(posedge clk);
      for (int k = 0; k < NL; k++)
         if (we[k]) mem_m[ea][k*LW +: LW] = dq_in[k*LW +: LW];
      s2v = s1v; s2d = s1d;
      s1v = nv;  s1d = nd;
      if (ld) begin
         m_act = sel; m_base = int'(addr); m_cnt = 0;
      end else if (m_act) begin
         m_cnt = cnt_n;
      end
      @(negedge clk);
      chk(dq_oe == (s2v && !drive_n), {tag, " dq_oe"}, DW'(dq_oe), DW'(s2v && !drive_n));
      if (s2v && !drive_n)
         chk(dq_out == s2d, {tag, " dq_out"}, dq_out, s2d);
   endtask

   task automatic cpu_read(input int a, input string tag);
      idle(); addr = AW'(a); cpu_load_n = 0; step(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%h expected=%h", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
      repeat (3) @(negedge clk);
      chk(dq_oe == 0, "R1 in reset", DW'(dq_oe), '0);
      rst_n = 1;
      idle();
      step("R1 idle"); step("R1 idle");

      // fill every word with controller write bursts, varying start beat
      for (int blk = 0; blk < DEPTH / 4; blk++) begin
         int st;
         st = blk * 4 + (blk % 4);
         idle(); addr = AW'(st); ctl_load_n = 0; wr_all_n = 0;
         lane_sel_n = NL'(blk); dq_in = pat(st);
         step("R5 load write");
         for (int k = 1; k < 4; k++) begin
            idle(); step_n = 0; wr_all_n = 0;
            dq_in = pat(blk * 4 + ((blk % 4 + k) % 4));
            step("R11 burst write");
         end
      end
      idle(); wr_all_n = 1;

      // read back with different start beats, wait state then three advances
      for (int blk = 0; blk < DEPTH / 4; blk++) begin
         cpu_read(blk * 4 + ((blk + 1) % 4), "R2 load read");
         idle(); step("R10 wait");
         for (int k = 1; k < 4; k++) begin
            idle(); step_n = 0; step("R9 advance");
         end
      end
      idle(); step("R9 tail"); step("R9 tail");

      // CPU load with write enables asserted performs a read
      idle(); addr = 5; cpu_load_n = 0; wr_all_n = 0; wr_lane_gate_n = 0;
      lane_sel_n = '0; dq_in = '1;
      step("R4 cpu load");
      idle(); step("R4 wait"); step("R4 wait"); step("R4 wait");
      cpu_read(5, "R4 reread"); idle(); step("R4"); step("R4");

      // lane writes
      idle(); addr = 10; ctl_load_n = 0; wr_lane_gate_n = 0;
      lane_sel_n = 2'b10; dq_in = 18'h2AAAA; step("R6 lane0");
      idle(); step_n = 0; wr_lane_gate_n = 0; lane_sel_n = 2'b01;
      dq_in = 18'h15555; step("R11 lane1 at next beat");
      idle(); lane_sel_n = 2'b00; dq_in = '1; step("R6 gate off read");
      step("R6"); step("R6");
      idle(); addr = 20; ctl_load_n = 0; wr_lane_gate_n = 1; lane_sel_n = 2'b11;
      wr_all_n = 0; dq_in = 18'h3C3C3; step("R5 global");
      cpu_read(10, "R6 readback"); idle(); step("R6"); step_n = 0; step("R6");
      idle(); step("R6"); step("R6");
      cpu_read(20, "R5 readback"); idle(); step("R5"); step("R5");

      // processor strobe ignored while primary enable high
      cpu_read(30, "R3 start"); idle(); step("R3");
      idle(); en_main_n = 1; cpu_load_n = 0; addr = 40; step("R3 ignored");
      step("R3 ignored"); idle(); step("R3"); step("R3");

      // enables change mid-burst
      cpu_read(50, "R7 start"); idle(); step("R7");
      idle(); en_hi = 0; en_aux_n = 1; en_main_n = 1; step_n = 0; step("R7 mid");
      step("R7 mid"); step("R7 mid"); idle(); step("R7"); step("R7");

      // deselect cases
      cpu_read(60, "R8 a"); idle(); en_hi = 0; addr = 61; cpu_load_n = 0;
      step("R8 en_hi low"); idle(); step("R8"); step("R8"); step("R8");
      cpu_read(61, "R8 b"); idle(); en_aux_n = 1; addr = 62; cpu_load_n = 0;
      step("R8 aux high"); idle(); step("R8"); step("R8");
      cpu_read(62, "R8 c"); idle(); en_main_n = 1; addr = 63; ctl_load_n = 0;
      wr_all_n = 0; dq_in = '0; step("R8 main high ctl");
      idle(); step("R8"); step("R8"); step("R8");
      cpu_read(63, "R8 reread"); idle(); step("R8"); step("R8");

      // asynchronous output enable
      drive_n = 1; #1;
      chk(dq_oe == 0, "R12 off", DW'(dq_oe), '0);
      chk(dq_out == 0, "R12 off data", dq_out, '0);
      drive_n = 0; #1;
      chk(dq_oe == 1, "R12 on", DW'(dq_oe), 1);
      chk(dq_out == mem_m[63], "R12 on data", dq_out, mem_m[63]);
      drive_n = 1; step("R12 held off"); drive_n = 0; step("R12");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule